// File: doc/BRIEF.md
# Magnetic Tape Controller Status Word Builder

This block assembles the two 16-bit status words that a tape controller presents to its host. It combines two kinds of state. The first is a set of controller-level error flags. Command and transfer logic raises these with one-cycle set strobes, and they stay latched. The second is a dynamic status vector kept separately for each attached drive. The block selects the vector of the currently addressed drive and places it into the words. It also forces a few constant bits and derives two summary error bits from fixed groups of flags. A separate flag records that a monitored bit of any drive has changed value.

The sequencing logic owns the rest of the controller. It writes new dynamic status into a chosen drive, reports which drives are attached, and pulses a start strobe at each new command and a clear strobe on a controller clear. It also pulses a drive-initialise strobe, which puts every drive into its power-on state. The host reads the two words combinationally from registered state, so any update is visible on the cycle after the clock edge that captured it.

Top module: `tape_status_agg`

## Requirements
- R1: Word 1 carries, from bit 15 down: summary error 1, data late, rewinding, illegal, high density, data error, end of tape, end of file, beginning of tape, nine-track, bad tape, bit 4, status change, write lock, odd character, ready.
- R2: Word 2 carries, from bit 15 down: summary error 2, runaway, false gap, bit 12, corrected data late, selected unit number in bits 10:8, word-count overflow, bad signal, overskew, CRC, single-track error, false preamble, format error, PE mode.
- R3: Word 1 bits 11 and 6 always read 1. Word 1 bit 4, word 2 bit 14 and word 2 bit 12 always read 0.
- R4: Word 1 bit 15 is 1 exactly when at least one of these is 1: data late, illegal, data error, end of tape, end of file, beginning of tape, bad tape or odd character.
- R5: Word 2 bit 15 is 1 exactly when at least one of these is 1: false gap, corrected data late, bad signal, overskew, CRC or false preamble. Word-count overflow, single-track error and format error do not affect it.
- R6: The rewinding, end of tape, end of file, beginning of tape, write lock, ready and PE bits come from the drive numbered by `sel_unit`, and they follow a change of `sel_unit` in the same cycle.
- R7: A cycle with `dyn_wr_en` high loads `dyn_wr_val` into drive `dyn_wr_unit` at the clock edge. The vector bits are: 0 ready, 1 write lock, 2 beginning of tape, 3 end of file, 4 end of tape, 5 rewinding, 6 PE.
- R8: A drive whose `drv_attached` bit is low holds an all-zero dynamic vector from the next clock edge on, whatever is written to it.
- R9: The status-change bit is set at the edge where any drive's rewinding, beginning of tape, write lock, ready or PE bit changes. A change that affects only end of file or end of tape leaves it unchanged.
- R10: `err_set` bits latch the controller flags: 0 data late, 1 illegal, 2 data error, 3 odd character, 4 bad tape, 5 false gap, 6 corrected data late, 7 word-count overflow, 8 bad signal, 9 overskew, 10 CRC, 11 single-track error, 12 false preamble, 13 format error. Latched flags and the status-change bit hold until `cmd_start` or `clr_pulse` clears them. A set strobe in the clearing cycle still takes effect.
- R11: When `init_drives` is pulsed, each attached drive gets ready set, keeps its PE bit, takes write lock from `drv_protect` and beginning of tape from `drv_at_origin`, and has all other bits zero. The pulse clears all latched flags and the status-change bit, and it does not set status change.
- R12: After reset, every drive vector, every flag and the status-change bit are zero, so word 1 reads 16'h0840 and word 2 reads the selected unit number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_unit | input | 3 | Currently addressed drive |
| drv_attached | input | 8 | Per-drive attached indication |
| drv_protect | input | 8 | Per-drive write protection, sampled on initialise |
| drv_at_origin | input | 8 | Per-drive position-at-zero, sampled on initialise |
| init_drives | input | 1 | Initialise all drives and clear latched state |
| dyn_wr_en | input | 1 | Write strobe for one drive's dynamic vector |
| dyn_wr_unit | input | 3 | Drive targeted by the write |
| dyn_wr_val | input | 7 | New dynamic vector |
| err_set | input | 14 | Set strobes for the controller error flags |
| cmd_start | input | 1 | New command started; clears latched flags and change |
| clr_pulse | input | 1 | Controller clear; clears latched flags and change |
| stat_word1 | output | 16 | Status word 1 |
| stat_word2 | output | 16 | Status word 2 |

## Verification
The assertions assume three things about the inputs. `init_drives` is a single-cycle pulse. `drv_attached` is meaningful on every cycle. `sel_unit` names a drive that exists. The stimulus keeps `drv_attached` mostly high and drops single bits only now and then, so detached drives are exercised without hiding the other checks. Initialise, start and clear pulses are rare, so flags and status change can build up across many cycles before a clear. Random set strobes are sparse and arrive in any cycle, including cycles that also clear.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int DYN_W = 7;
  localparam int DY_RDY = 0;
  localparam int DY_WLK = 1;
  localparam int DY_BOT = 2;
  localparam int DY_EOF = 3;
  localparam int DY_EOT = 4;
  localparam int DY_REW = 5;
  localparam int DY_PEM = 6;
  localparam logic [DYN_W-1:0] DY_MON_MASK = 7'b110_0111;

  localparam int FL_W = 14;
  localparam int FL_DLT = 0;
  localparam int FL_ILL = 1;
  localparam int FL_DAE = 2;
  localparam int FL_ODD = 3;
  localparam int FL_BAT = 4;
  localparam int FL_FGP = 5;
  localparam int FL_CDL = 6;
  localparam int FL_WCO = 7;
  localparam int FL_BDS = 8;
  localparam int FL_OVS = 9;
  localparam int FL_CRC = 10;
  localparam int FL_STE = 11;
  localparam int FL_FPR = 12;
  localparam int FL_FMT = 13;

  localparam int WORD_W = 16;

  typedef logic [DYN_W-1:0]  dyn_t;
  typedef logic [FL_W-1:0]   flags_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/tsa_drive_bank.sv
module tsa_drive_bank
  import tsa_pkg::*;
#(
  parameter int N_DRV  = 8,
  parameter int UNIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_DRV-1:0]  attached,
  input  logic [N_DRV-1:0]  protect,
  input  logic [N_DRV-1:0]  at_origin,
  input  logic              init_drv,
  input  logic              wr_en,
  input  logic [UNIT_W-1:0] wr_unit,
  input  dyn_t              wr_val,
  input  logic [UNIT_W-1:0] sel_unit,
  output dyn_t              sel_dyn,
  output logic              mon_change
);
  logic [N_DRV-1:0][DYN_W-1:0] dyn_all;
  logic [N_DRV-1:0]            chg_vec;

  for (genvar i = 0; i < N_DRV; i++) begin : g_drv
    dyn_t dyn_q;
    dyn_t dyn_raw;
    dyn_t dyn_d;
    logic hit;

    assign hit = wr_en && (wr_unit == UNIT_W'(i));

    always_comb begin
      if (init_drv) begin
        dyn_raw          = '0;
        dyn_raw[DY_RDY]  = 1'b1;
        dyn_raw[DY_WLK]  = protect[i];
        dyn_raw[DY_BOT]  = at_origin[i];
        dyn_raw[DY_PEM]  = dyn_q[DY_PEM];
      end else if (hit) begin
        dyn_raw = wr_val;
      end else begin
        dyn_raw = dyn_q;
      end
      dyn_d = attached[i] ? dyn_raw : '0;
    end

    assign chg_vec[i] = !init_drv && (((dyn_d ^ dyn_q) & DY_MON_MASK) != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dyn_q <= '0;
      else        dyn_q <= dyn_d;
    end

    assign dyn_all[i] = dyn_q;

    AST_OFFLINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !attached[i] |=> (dyn_q == '0)); // R8
    AST_INIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (init_drv && attached[i]) |=> (dyn_q[DY_RDY] && dyn_q[DY_EOF:DY_BOT] == 2'b00 || dyn_q[DY_RDY] && !dyn_q[DY_EOF])); // R11
  end

  always_comb begin
    sel_dyn = '0;
    for (int k = 0; k < N_DRV; k++) begin
      if (sel_unit == UNIT_W'(k)) sel_dyn = dyn_all[k];
    end
  end

  assign mon_change = |chg_vec;
endmodule

// File: rtl/tsa_flag_latch.sv
module tsa_flag_latch
  import tsa_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  flags_t set_strb,
  input  logic   cmd_start,
  input  logic   clr_pulse,
  input  logic   init_drv,
  input  logic   mon_change,
  output flags_t flags_q,
  output logic   chg_q
);
  logic   clr_c;
  flags_t flags_d;
  logic   chg_d;

  assign clr_c = cmd_start || clr_pulse || init_drv;

  always_comb begin
    flags_d = (clr_c ? '0 : flags_q) | set_strb;
    chg_d   = (clr_c ? 1'b0 : chg_q) | mon_change;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      chg_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      chg_q   <= chg_d;
    end
  end

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_c |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R10
  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_start || clr_pulse) && set_strb == '0) |=> (flags_q == '0)); // R10
  AST_INIT_NO_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    init_drv |=> !chg_q); // R11
endmodule

// File: rtl/tsa_word_build.sv
module tsa_word_build
  import tsa_pkg::*;
#(
  parameter int UNIT_W = 3
) (
  input  flags_t            flags,
  input  logic              chg,
  input  dyn_t              dyn,
  input  logic [UNIT_W-1:0] unit,
  output word_t             word1,
  output word_t             word2
);
  logic err1;
  logic err2;

  assign err1 = flags[FL_DLT] | flags[FL_ILL] | flags[FL_DAE] | flags[FL_BAT] |
                flags[FL_ODD] | dyn[DY_EOT] | dyn[DY_EOF] | dyn[DY_BOT];
  assign err2 = flags[FL_FGP] | flags[FL_CDL] | flags[FL_BDS] |
                flags[FL_OVS] | flags[FL_CRC] | flags[FL_FPR];

  always_comb begin
    word1     = '0;
    word1[15] = err1;
    word1[14] = flags[FL_DLT];
    word1[13] = dyn[DY_REW];
    word1[12] = flags[FL_ILL];
    word1[11] = 1'b1;
    word1[10] = flags[FL_DAE];
    word1[9]  = dyn[DY_EOT];
    word1[8]  = dyn[DY_EOF];
    word1[7]  = dyn[DY_BOT];
    word1[6]  = 1'b1;
    word1[5]  = flags[FL_BAT];
    word1[3]  = chg;
    word1[2]  = dyn[DY_WLK];
    word1[1]  = flags[FL_ODD];
    word1[0]  = dyn[DY_RDY];

    word2       = '0;
    word2[15]   = err2;
    word2[13]   = flags[FL_FGP];
    word2[11]   = flags[FL_CDL];
    word2[10:8] = 3'(unit);
    word2[7]    = flags[FL_WCO];
    word2[6]    = flags[FL_BDS];
    word2[5]    = flags[FL_OVS];
    word2[4]    = flags[FL_CRC];
    word2[3]    = flags[FL_STE];
    word2[2]    = flags[FL_FPR];
    word2[1]    = flags[FL_FMT];
    word2[0]    = dyn[DY_PEM];
  end
endmodule

// File: rtl/tape_status_agg.sv
module tape_status_agg
  import tsa_pkg::*;
#(
  parameter int N_DRV = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       sel_unit,
  input  logic [N_DRV-1:0] drv_attached,
  input  logic [N_DRV-1:0] drv_protect,
  input  logic [N_DRV-1:0] drv_at_origin,
  input  logic             init_drives,
  input  logic             dyn_wr_en,
  input  logic [2:0]       dyn_wr_unit,
  input  logic [6:0]       dyn_wr_val,
  input  logic [13:0]      err_set,
  input  logic             cmd_start,
  input  logic             clr_pulse,
  output logic [15:0]      stat_word1,
  output logic [15:0]      stat_word2
);
  localparam int UNIT_W = 3;

  logic [1:0] rst_pipe;
  logic       rst_int_n;
  dyn_t       sel_dyn;
  logic       mon_change;
  flags_t     flags_q;
  logic       chg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  tsa_drive_bank #(.N_DRV(N_DRV), .UNIT_W(UNIT_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .attached   (drv_attached),
    .protect    (drv_protect),
    .at_origin  (drv_at_origin),
    .init_drv   (init_drives),
    .wr_en      (dyn_wr_en),
    .wr_unit    (dyn_wr_unit),
    .wr_val     (dyn_wr_val),
    .sel_unit   (sel_unit),
    .sel_dyn    (sel_dyn),
    .mon_change (mon_change)
  );

  tsa_flag_latch u_flags (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .set_strb   (err_set),
    .cmd_start  (cmd_start),
    .clr_pulse  (clr_pulse),
    .init_drv   (init_drives),
    .mon_change (mon_change),
    .flags_q    (flags_q),
    .chg_q      (chg_q)
  );

  tsa_word_build #(.UNIT_W(UNIT_W)) u_words (
    .flags (flags_q),
    .chg   (chg_q),
    .dyn   (sel_dyn),
    .unit  (sel_unit),
    .word1 (stat_word1),
    .word2 (stat_word2)
  );

  AST_CHG_VISIBLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($stable(sel_unit) && !$past(init_drives) &&
     ({$past(stat_word1[13]), $past(stat_word1[7]), $past(stat_word1[2]),
       $past(stat_word1[0]), $past(stat_word2[0])} !=
      {stat_word1[13], stat_word1[7], stat_word1[2], stat_word1[0], stat_word2[0]}))
    |-> stat_word1[3]); // R9
  AST_UNIT_FIELD: assert property (@(posedge clk) disable iff (!rst_int_n)
    stat_word2[10:8] == sel_unit); // R2
endmodule

// File: tb/tape_status_agg_test.sv
module tape_status_agg_test;
  logic        clk;
  logic        rst_n;
  logic [2:0]  sel_unit;
  logic [7:0]  drv_attached;
  logic [7:0]  drv_protect;
  logic [7:0]  drv_at_origin;
  logic        init_drives;
  logic        dyn_wr_en;
  logic [2:0]  dyn_wr_unit;
  logic [6:0]  dyn_wr_val;
  logic [13:0] err_set;
  logic        cmd_start;
  logic        clr_pulse;
  logic [15:0] stat_word1;
  logic [15:0] stat_word2;

  int n_vec = 0;
  int n_bad = 0;

  logic [6:0]  m_dyn [8];
  logic [13:0] m_fl;
  logic        m_chg;

  tape_status_agg uut (
    .clk(clk), .rst_n(rst_n), .sel_unit(sel_unit), .drv_attached(drv_attached),
    .drv_protect(drv_protect), .drv_at_origin(drv_at_origin),
    .init_drives(init_drives), .dyn_wr_en(dyn_wr_en), .dyn_wr_unit(dyn_wr_unit),
    .dyn_wr_val(dyn_wr_val), .err_set(err_set), .cmd_start(cmd_start),
    .clr_pulse(clr_pulse), .stat_word1(stat_word1), .stat_word2(stat_word2)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] exp_w1(input logic [2:0] s);
    logic [6:0] d;
    logic [15:0] w;
    d = m_dyn[s];
    w = 16'h0840;
    w[14] = m_fl[0]; w[13] = d[5]; w[12] = m_fl[1]; w[10] = m_fl[2];
    w[9] = d[4]; w[8] = d[3]; w[7] = d[2]; w[5] = m_fl[4]; w[3] = m_chg;
    w[2] = d[1]; w[1] = m_fl[3]; w[0] = d[0];
    w[15] = m_fl[0] | m_fl[1] | m_fl[2] | m_fl[3] | m_fl[4] | d[4] | d[3] | d[2];
    return w;
  endfunction

  function automatic logic [15:0] exp_w2(input logic [2:0] s);
    logic [15:0] w;
    w = 16'h0000;
    w[13] = m_fl[5]; w[11] = m_fl[6]; w[10:8] = s; w[7] = m_fl[7];
    w[6] = m_fl[8]; w[5] = m_fl[9]; w[4] = m_fl[10]; w[3] = m_fl[11];
    w[2] = m_fl[12]; w[1] = m_fl[13]; w[0] = m_dyn[s][6];
    w[15] = m_fl[5] | m_fl[6] | m_fl[8] | m_fl[9] | m_fl[10] | m_fl[12];
    return w;
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // advance the model for the inputs now applied
  task automatic model_step();
    logic clr;
    logic any;
    logic [6:0] raw;
    logic [6:0] nd;
    clr = cmd_start | clr_pulse | init_drives;
    any = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (init_drives) raw = {m_dyn[i][6], 3'b000, drv_at_origin[i], drv_protect[i], 1'b1};
      else if (dyn_wr_en && dyn_wr_unit == 3'(i)) raw = dyn_wr_val;
      else raw = m_dyn[i];
      nd = drv_attached[i] ? raw : 7'd0;
      if (!init_drives && (((nd ^ m_dyn[i]) & 7'b1100111) != 7'd0)) any = 1'b1;
      m_dyn[i] = nd;
    end
    m_fl  = (clr ? 14'd0 : m_fl) | err_set;
    m_chg = (clr ? 1'b0 : m_chg) | any;
  endtask

  task automatic idle_inputs();
    init_drives = 1'b0; dyn_wr_en = 1'b0; dyn_wr_unit = 3'd0; dyn_wr_val = 7'd0;
    err_set = 14'd0; cmd_start = 1'b0; clr_pulse = 1'b0;
  endtask

  // one clock, then compare both words under the given tags
  task automatic cyc(input string t1, input string t2);
    model_step();
    @(negedge clk);
    chk(t1, stat_word1, exp_w1(sel_unit));
    chk(t2, stat_word2, exp_w2(sel_unit));
    idle_inputs();
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240517);
    idle_inputs();
    sel_unit = 3'd0; drv_attached = 8'hFF; drv_protect = 8'h0F; drv_at_origin = 8'h55;
    for (int i = 0; i < 8; i++) m_dyn[i] = 7'd0;
    m_fl = 14'd0; m_chg = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state, R3 constant bits
    chk("R12", stat_word1, 16'h0840);
    chk("R12", stat_word2, 16'h0000);
    chk("R3", {stat_word1[11], stat_word1[6], stat_word1[4], stat_word2[14], stat_word2[12]}, 16'h0018);

    // R11 initialise: drive 0 attached, protected, at origin
    init_drives = 1'b1; err_set = 14'h0002;
    cyc("R11", "R11");
    chk("R11 no change", {15'd0, stat_word1[3]}, 16'd0);

    // R9 only end-of-file changes on drive 3: no status change
    sel_unit = 3'd3;
    dyn_wr_en = 1'b1; dyn_wr_unit = 3'd3; dyn_wr_val = 7'b0001011;
    cyc("R9", "R7");
    chk("R9 eof only", {15'd0, stat_word1[3]}, 16'd0);
    // R9 rewinding on drive 6 while drive 3 selected
    dyn_wr_en = 1'b1; dyn_wr_unit = 3'd6; dyn_wr_val = 7'b0100000;
    cyc("R9", "R2");
    chk("R9 other drive", {15'd0, stat_word1[3]}, 16'd1);

    // R10 clear with simultaneous illegal strobe
    clr_pulse = 1'b1; err_set = 14'h0002;
    cyc("R10", "R10");
    cyc("R10", "R10");
    cmd_start = 1'b1;
    cyc("R10", "R10");

    // R4 / R5 summary groups; drive 1 has no BOT/EOF/EOT
    sel_unit = 3'd1;
    err_set = 14'h0010; cyc("R4", "R5");
    cmd_start = 1'b1; err_set = 14'h0400; cyc("R4", "R5");
    cmd_start = 1'b1; err_set = 14'h2880; cyc("R4", "R5");
    cmd_start = 1'b1; err_set = 14'h1000; cyc("R4", "R5");

    // R8 detached drive 5 reads zero despite write
    sel_unit = 3'd5; drv_attached = 8'hDF;
    dyn_wr_en = 1'b1; dyn_wr_unit = 3'd5; dyn_wr_val = 7'b1111111;
    cyc("R8", "R8");
    drv_attached = 8'hFF;

    // R6 selection sweep with PE on drive 2
    dyn_wr_en = 1'b1; dyn_wr_unit = 3'd2; dyn_wr_val = 7'b1010101;
    cyc("R7", "R7");
    for (int s = 0; s < 8; s++) begin
      sel_unit = 3'(s);
      #1;
      chk("R6", stat_word1, exp_w1(sel_unit));
      chk("R6", stat_word2, exp_w2(sel_unit));
    end

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      sel_unit    = 3'($urandom);
      dyn_wr_en   = ($urandom % 3) != 0;
      dyn_wr_unit = 3'($urandom);
      dyn_wr_val  = 7'($urandom);
      err_set     = 14'($urandom & $urandom & $urandom & $urandom);
      cmd_start   = ($urandom % 16) == 0;
      clr_pulse   = ($urandom % 32) == 0;
      init_drives = ($urandom % 64) == 0;
      drv_protect = 8'($urandom);
      drv_at_origin = 8'($urandom);
      if (($urandom % 10) == 0) drv_attached = drv_attached ^ (8'd1 << ($urandom % 8));
      if (($urandom % 10) == 0) drv_attached = 8'hFF;
      cyc("R1", "R2");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule